// File: doc/BRIEF.md
# Quad-SPI Flash Word Reader

This block lets a slow processor fetch 16-bit words from a serial NOR flash as if the flash were a ROM. The processor raises a request with a word address. The block then runs one complete read on the flash with chip-select held low. Every phase moves four bits per serial clock. The phases are a command byte, a 24-bit byte address, a gap of dummy clocks with the data lines released, and two data bytes captured from the flash. At the end the block returns the word with a one-cycle acknowledge.

The serial clock runs at half the block clock. The dummy gap comes from an input and is latched when the request is accepted. It is limited so that a whole transfer, plus one clock of chip-select recovery, fits inside the window of serial clocks that one processor access allows. The byte address is the word address doubled plus a base offset, so the ROM image can sit anywhere in the flash. Between transfers the block drives the two upper data lines high, because those lines are the flash's write-protect and hold pins.

Top module: `qspiWordReader`

## Requirements
- R1: While chip-select (`flashCsN`) is high, including after reset, `flashSclk` is 0 and `reqAck` is 0. `flashDqOe` is 4'b1100 and `flashDqOut[3:2]` is 2'b11, so the write-protect and hold lines are driven high and lines 1:0 are released.
- R2: A request is accepted at a clock edge where the block is idle and `reqValid` is 1. `flashCsN` falls in the next cycle. The first two serial clocks carry the command byte `READ_CMD` (default 8'hEB), high nibble first, with `flashDqOut[3]` as the most significant bit and `flashDqOe` = 4'hF.
- R3: The next six serial clocks carry the byte address, most significant nibble first, with `flashDqOe` = 4'hF. The byte address is (`reqWordAddr` << 1) + `baseOffset`, modulo 2^24.
- R4: Next come D dummy clocks with `flashDqOe` = 4'h0, where D is `dummyCount` sampled at acceptance. D may be 0.
- R5: The last four serial clocks have `flashDqOe` = 4'h0. `flashDqIn` is captured in each of them. The first nibble becomes `rdData[15:12]` and the last becomes `rdData[3:0]`.
- R6: Each serial clock lasts two block cycles: `flashSclk` is low in the first and high in the second. `flashDqOut` changes only at the start of a low cycle. `flashDqIn` is sampled at the edge that ends the high cycle. `reqAck` comes exactly 2*(12+D)+1 cycles after the accepting edge.
- R7: `reqAck` is a single-cycle pulse. It comes in the first cycle that chip-select is high again, and `rdData` is valid in that cycle.
- R8: Between two transfers, chip-select stays high for at least two block cycles, which is one serial clock.
- R9: While a transfer is in progress, `reqValid`, `reqWordAddr`, `baseOffset` and `dummyCount` are ignored. A request held high through the acknowledge is served as a new transfer once the block is idle again.
- R10: A `dummyCount` above `WINDOW_CLKS`-13 (19 by default) is treated as that limit. A transfer therefore spans at most `WINDOW_CLKS`-1 serial clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; the serial clock is half this rate |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Processor read request |
| reqWordAddr | input | ADDR_W | Word address of the request |
| baseOffset | input | 24 | Byte offset added to the doubled word address |
| dummyCount | input | DUMMY_W | Dummy clocks between address and data |
| reqAck | output | 1 | One-cycle acknowledge with data |
| rdData | output | 16 | Returned word |
| flashCsN | output | 1 | Flash chip-select, active low |
| flashSclk | output | 1 | Flash serial clock |
| flashDqOut | output | 4 | Values driven onto the four data lines |
| flashDqOe | output | 4 | Per-line output enable |
| flashDqIn | input | 4 | Values read from the four data lines |

## Verification
The hardest case to reach from the ports is a request held high through the acknowledge while its address, offset and dummy inputs change in the middle of a transfer. The design must ignore the changes, hold chip-select high for the recovery gap, and then start a fresh transfer from the new values. The bench reaches this in two ways. First, it scrambles every request input a few cycles after acceptance. Second, it runs a back-to-back pair in which the second address is presented in the cycle right after the acknowledge. A reference model in the bench predicts every bus cycle, and a behavioural flash model decodes the address from the bus. Dummy settings of 0, the limit and above the limit exercise the phase boundaries and the clamp.

// File: rtl/qspiRdPkg.sv
package qspiRdPkg;

  typedef enum logic [1:0] {
    PH_CMD,
    PH_ADDR,
    PH_DUMMY,
    PH_DATA
  } phase_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_XFER,
    ST_GAP
  } ctrlState_e;

  // strobes from sequencer to datapath
  typedef struct packed {
    logic load;      // latch command and byte address
    logic advance;   // move next outgoing nibble to the top
    logic capture;   // take one incoming nibble
    logic finish;    // form the returned word
    logic active;    // chip-select asserted
    logic driveBus;  // data lines are outputs
  } dpCtrl_t;

  localparam int CMD_CLKS   = 2;
  localparam int ADDR_CLKS  = 6;
  localparam int DATA_CLKS  = 4;
  localparam int FIXED_CLKS = CMD_CLKS + ADDR_CLKS + DATA_CLKS;

endpackage

// File: rtl/qspiRdCtrl.sv
module qspiRdCtrl
  import qspiRdPkg::*;
#(
  parameter int WINDOW_CLKS = 32,
  parameter int DUMMY_W     = 5
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               reqValid,
  input  logic [DUMMY_W-1:0] dummyCount,
  output dpCtrl_t            strobes,
  output logic               reqAck,
  output logic               flashCsN,
  output logic               flashSclk
);

  localparam int CNT_W     = $clog2(WINDOW_CLKS + 1);
  localparam int MAX_DUMMY = WINDOW_CLKS - FIXED_CLKS - 1;
  localparam int ADDR_END  = CMD_CLKS + ADDR_CLKS;

  ctrlState_e         state;
  logic               half;
  logic               gapSecond;
  logic [CNT_W-1:0]   clkIdx;
  logic [DUMMY_W-1:0] dummyLat;
  logic [DUMMY_W-1:0] dummyEff;
  logic [CNT_W-1:0]   dataStart;
  logic [CNT_W-1:0]   lastIdx;
  phase_e             phase;
  logic               inXfer;

  always_comb begin
    if (int'(dummyCount) > MAX_DUMMY) dummyEff = DUMMY_W'(MAX_DUMMY);
    else                              dummyEff = dummyCount;
  end

  assign dataStart = CNT_W'(ADDR_END) + CNT_W'(dummyLat);
  assign lastIdx   = dataStart + CNT_W'(DATA_CLKS - 1);

  always_comb begin
    if (clkIdx < CNT_W'(CMD_CLKS))      phase = PH_CMD;
    else if (clkIdx < CNT_W'(ADDR_END)) phase = PH_ADDR;
    else if (clkIdx < dataStart)        phase = PH_DUMMY;
    else                                phase = PH_DATA;
  end

  assign inXfer = (state == ST_XFER);

  always_comb begin
    strobes.load     = (state == ST_IDLE) && reqValid;
    strobes.advance  = inXfer && half && (phase != PH_DATA);
    strobes.capture  = inXfer && half && (phase == PH_DATA);
    strobes.finish   = inXfer && half && (clkIdx == lastIdx);
    strobes.active   = inXfer;
    strobes.driveBus = inXfer && ((phase == PH_CMD) || (phase == PH_ADDR));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      half      <= 1'b0;
      gapSecond <= 1'b0;
      clkIdx    <= '0;
      dummyLat  <= '0;
      reqAck    <= 1'b0;
    end else begin
      reqAck <= strobes.finish;
      case (state)
        ST_IDLE: begin
          if (reqValid) begin
            state    <= ST_XFER;
            half     <= 1'b0;
            clkIdx   <= '0;
            dummyLat <= dummyEff;
          end
        end
        ST_XFER: begin
          half <= ~half;
          if (half) begin
            if (clkIdx == lastIdx) begin
              state     <= ST_GAP;
              gapSecond <= 1'b0;
            end else begin
              clkIdx <= clkIdx + CNT_W'(1);
            end
          end
        end
        ST_GAP: begin
          if (gapSecond) state <= ST_IDLE;
          else           gapSecond <= 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign flashCsN  = !inXfer;
  assign flashSclk = inXfer && half;

endmodule

// File: rtl/qspiRdDatapath.sv
module qspiRdDatapath
  import qspiRdPkg::*;
#(
  parameter int         ADDR_W   = 23,
  parameter logic [7:0] READ_CMD = 8'hEB
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtrl_t           strobes,
  input  logic [ADDR_W-1:0] reqWordAddr,
  input  logic [23:0]       baseOffset,
  input  logic [3:0]        flashDqIn,
  output logic [3:0]        flashDqOut,
  output logic [3:0]        flashDqOe,
  output logic [15:0]       rdData
);

  localparam logic [3:0] IDLE_DRIVE = 4'b1100;
  localparam int         SHIFT_W    = 8 + 24;

  logic [23:0]        byteAddr;
  logic [SHIFT_W-1:0] outShift;
  logic [11:0]        inShift;

  assign byteAddr = 24'({reqWordAddr, 1'b0}) + baseOffset;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outShift <= '0;
      inShift  <= '0;
      rdData   <= '0;
    end else begin
      if (strobes.load)         outShift <= {READ_CMD, byteAddr};
      else if (strobes.advance) outShift <= {outShift[SHIFT_W-5:0], 4'h0};
      if (strobes.capture)      inShift  <= {inShift[7:0], flashDqIn};
      if (strobes.finish)       rdData   <= {inShift, flashDqIn};
    end
  end

  always_comb begin
    if (!strobes.active) begin
      flashDqOe  = IDLE_DRIVE;
      flashDqOut = IDLE_DRIVE;
    end else begin
      flashDqOe  = strobes.driveBus ? 4'hF : 4'h0;
      flashDqOut = outShift[SHIFT_W-1:SHIFT_W-4];
    end
  end

endmodule

// File: rtl/qspiWordReader.sv
module qspiWordReader
  import qspiRdPkg::*;
#(
  parameter int         ADDR_W      = 23,
  parameter int         DUMMY_W     = 5,
  parameter int         WINDOW_CLKS = 32,
  parameter logic [7:0] READ_CMD    = 8'hEB
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               reqValid,
  input  logic [ADDR_W-1:0]  reqWordAddr,
  input  logic [23:0]        baseOffset,
  input  logic [DUMMY_W-1:0] dummyCount,
  output logic               reqAck,
  output logic [15:0]        rdData,
  output logic               flashCsN,
  output logic               flashSclk,
  output logic [3:0]         flashDqOut,
  output logic [3:0]         flashDqOe,
  input  logic [3:0]         flashDqIn
);

  dpCtrl_t strobes;

  qspiRdCtrl #(
    .WINDOW_CLKS(WINDOW_CLKS),
    .DUMMY_W    (DUMMY_W)
  ) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .reqValid  (reqValid),
    .dummyCount(dummyCount),
    .strobes   (strobes),
    .reqAck    (reqAck),
    .flashCsN  (flashCsN),
    .flashSclk (flashSclk)
  );

  qspiRdDatapath #(
    .ADDR_W  (ADDR_W),
    .READ_CMD(READ_CMD)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .reqWordAddr(reqWordAddr),
    .baseOffset (baseOffset),
    .flashDqIn  (flashDqIn),
    .flashDqOut (flashDqOut),
    .flashDqOe  (flashDqOe),
    .rdData     (rdData)
  );

endmodule

// File: rtl/qspiWordReaderChk.sv
module qspiWordReaderChk #(
  parameter int WINDOW_CLKS = 32
) (
  input logic       clk,
  input logic       rstN,
  input logic       reqAck,
  input logic       flashCsN,
  input logic       flashSclk,
  input logic [3:0] flashDqOut,
  input logic [3:0] flashDqOe
);

  localparam int LOW_LIMIT = 2 * (WINDOW_CLKS - 1);

  int lowPrev;

  always_ff @(posedge clk) begin
    if (!rstN)          lowPrev <= 0;
    else if (flashCsN)  lowPrev <= 0;
    else                lowPrev <= lowPrev + 1;
  end

  // R1
  idle_drive_chk: assert property (@(posedge clk) disable iff (!rstN)
    flashCsN |-> (flashDqOe == 4'b1100 && flashDqOut[3:2] == 2'b11 && !flashSclk));

  // R6
  out_stable_high_chk: assert property (@(posedge clk) disable iff (!rstN)
    flashSclk |-> $stable(flashDqOut));

  // R2
  oe_group_chk: assert property (@(posedge clk) disable iff (!rstN)
    !flashCsN |-> (flashDqOe == 4'hF || flashDqOe == 4'h0));

  // R7
  ack_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    reqAck |=> !reqAck);

  // R7
  ack_at_cs_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    reqAck |-> $rose(flashCsN));

  // R8
  cs_gap_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(flashCsN) |=> flashCsN);

  // R10
  window_fit_chk: assert property (@(posedge clk) disable iff (!rstN)
    !flashCsN |-> (lowPrev < LOW_LIMIT));

endmodule

bind qspiWordReader qspiWordReaderChk #(
  .WINDOW_CLKS(WINDOW_CLKS)
) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .reqAck    (reqAck),
  .flashCsN  (flashCsN),
  .flashSclk (flashSclk),
  .flashDqOut(flashDqOut),
  .flashDqOe (flashDqOe)
);

// File: tb/qspiWordReader_tb.sv
module qspiWordReader_tb;

  localparam int MAX_D = 19;

  logic        clk = 1'b0;
  logic        rstN;
  logic        reqValid;
  logic [22:0] reqWordAddr;
  logic [23:0] baseOffset;
  logic [4:0]  dummyCount;
  logic        reqAck;
  logic [15:0] rdData;
  logic        flashCsN;
  logic        flashSclk;
  logic [3:0]  flashDqOut;
  logic [3:0]  flashDqOe;
  logic [3:0]  flashDqIn;

  int checks = 0;
  int failures = 0;
  int cyc = 0;

  always #4 clk = ~clk;

  qspiWordReader u_dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWordAddr(reqWordAddr),
    .baseOffset(baseOffset), .dummyCount(dummyCount), .reqAck(reqAck),
    .rdData(rdData), .flashCsN(flashCsN), .flashSclk(flashSclk),
    .flashDqOut(flashDqOut), .flashDqOe(flashDqOe), .flashDqIn(flashDqIn)
  );

  typedef struct {
    bit       csN;
    bit       sclk;
    bit [3:0] oe;
    bit [3:0] out;
    bit       ack;
    string    tag;
  } exp_t;

  exp_t        expQ[$];
  logic [15:0] dataQ[$];

  // flash model state
  int          fallCnt = 0;
  int          riseCnt = 0;
  bit          prevSclk = 0;
  logic [23:0] fAddr = '0;
  int          fD = 0;

  function automatic logic [15:0] memWord(input logic [23:0] ba);
    return ba[15:0] ^ {ba[23:16], 8'h5A} ^ 16'h3C96;
  endfunction

  function automatic exp_t mkE(bit c, bit s, bit [3:0] oe, bit [3:0] o, bit a, string t);
    exp_t e;
    e.csN = c; e.sclk = s; e.oe = oe; e.out = o; e.ack = a; e.tag = t;
    return e;
  endfunction

  task automatic pushTxn();
    int d;
    logic [23:0] ba;
    logic [31:0] seq;
    d   = (int'(dummyCount) > MAX_D) ? MAX_D : int'(dummyCount);
    ba  = 24'({reqWordAddr, 1'b0}) + baseOffset;
    seq = {8'hEB, ba};
    fD  = d;
    for (int i = 0; i < 12 + d; i++) begin
      bit [3:0] oe;
      bit [3:0] nib;
      string t;
      oe  = (i < 8) ? 4'hF : 4'h0;
      nib = (i < 8) ? seq[31 - 4*i -: 4] : 4'h0;
      if (i < 2) t = "R2";
      else if (i < 8) t = "R3";
      else if (i < 8 + d) t = (int'(dummyCount) > MAX_D) ? "R10" : "R4";
      else t = "R5";
      expQ.push_back(mkE(0, 0, oe, nib, 0, t));
      expQ.push_back(mkE(0, 1, oe, nib, 0, "R6"));
    end
    expQ.push_back(mkE(1, 0, 4'hC, 4'hC, 1, "R7"));
    expQ.push_back(mkE(1, 0, 4'hC, 4'hC, 0, "R8"));
    dataQ.push_back(memWord(ba));
  endtask

  // reference model compare on every cycle, plus flash model
  always @(negedge clk) begin
    exp_t e;
    bit wasIdle;
    logic [15:0] w;
    int j;
    if (rstN === 1'b1) begin
      wasIdle = (expQ.size() == 0);
      if (wasIdle) e = mkE(1, 0, 4'hC, 4'hC, 0, "R1");
      else         e = expQ.pop_front();
      checks++;
      if (flashCsN !== e.csN || flashSclk !== e.sclk || flashDqOe !== e.oe ||
          reqAck !== e.ack || (flashDqOut & e.oe) !== (e.out & e.oe)) begin
        failures++;
        $display("FAIL %s cyc=%0d actual cs=%b sclk=%b oe=%h out=%h ack=%b expected cs=%b sclk=%b oe=%h out=%h ack=%b",
                 e.tag, cyc, flashCsN, flashSclk, flashDqOe, flashDqOut, reqAck,
                 e.csN, e.sclk, e.oe, e.out, e.ack);
      end
      if (e.ack && dataQ.size() > 0) begin
        w = dataQ.pop_front();
        checks++;
        if (rdData !== w) begin
          failures++;
          $display("FAIL R5/R9 cyc=%0d rdData actual=%h expected=%h", cyc, rdData, w);
        end
      end
      if (wasIdle && reqValid === 1'b1) pushTxn();

      if (flashCsN) begin
        fallCnt  = 0;
        riseCnt  = 0;
        prevSclk = 0;
      end else begin
        if (prevSclk && !flashSclk) begin
          fallCnt++;
          j = fallCnt - 8 - fD;
          if (j >= 0 && j < 4) begin
            w = memWord(fAddr) >> (12 - 4*j);
            flashDqIn = w[3:0];
          end
        end
        if (!prevSclk && flashSclk) begin
          if (riseCnt >= 2 && riseCnt < 8) fAddr = {fAddr[19:0], flashDqOut};
          riseCnt++;
        end
        prevSclk = flashSclk;
      end
      // first data nibble with zero dummy clocks arrives in clock 8
      if (!flashCsN && fD == 0 && fallCnt == 8 && !flashSclk) begin
        w = memWord(fAddr) >> 12;
        flashDqIn = w[3:0];
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000) begin
      failures++;
      $display("FAIL watchdog expired at cycle %0d", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  // one request; inputs scrambled mid-transfer (R9)
  task automatic issue(input logic [22:0] a, input logic [23:0] b, input logic [4:0] d);
    @(posedge clk); #2;
    reqWordAddr = a; baseOffset = b; dummyCount = d; reqValid = 1'b1;
    repeat (6) @(posedge clk);
    #2;
    reqWordAddr = ~a; baseOffset = ~b; dummyCount = ~d;
    do @(negedge clk); while (reqAck !== 1'b1);
    @(posedge clk); #2;
    reqValid = 1'b0;
  endtask

  // request held through the acknowledge, new address presented after it (R9)
  task automatic backToBack(input logic [22:0] a1, input logic [22:0] a2);
    @(posedge clk); #2;
    reqWordAddr = a1; baseOffset = 24'h004000; dummyCount = 5'd10; reqValid = 1'b1;
    do @(negedge clk); while (reqAck !== 1'b1);
    @(posedge clk); #2;
    reqWordAddr = a2; dummyCount = 5'd7;
    do @(negedge clk); while (reqAck !== 1'b1);
    @(posedge clk); #2;
    reqValid = 1'b0;
  endtask

  initial begin
    rstN = 1'b0; reqValid = 1'b0; reqWordAddr = '0; baseOffset = '0;
    dummyCount = 5'd10; flashDqIn = 4'h0;
    repeat (3) @(posedge clk);
    #2 rstN = 1'b1;
    @(negedge clk);
    checks++;
    if (flashCsN !== 1'b1 || flashSclk !== 1'b0 || reqAck !== 1'b0 ||
        flashDqOe !== 4'b1100 || flashDqOut[3:2] !== 2'b11) begin
      failures++;
      $display("FAIL R1 reset state actual cs=%b sclk=%b ack=%b oe=%h out=%h expected cs=1 sclk=0 ack=0 oe=c out=11xx",
               flashCsN, flashSclk, reqAck, flashDqOe, flashDqOut);
    end
    issue(23'h000010, 24'h000000, 5'd10);
    issue(23'h012345, 24'h100000, 5'd10);
    issue(23'h7FFFFF, 24'hFFFFFF, 5'd10);  // R3 address wrap
    issue(23'h2A5A5A, 24'h000301, 5'd0);   // R4 no dummy clocks
    issue(23'h155555, 24'h020000, 5'd19);  // R4 at the limit
    issue(23'h0F0F0F, 24'h000000, 5'd31);  // R10 clamp
    issue(23'h3C3C3C, 24'h7F0000, 5'd20);  // R10 just above limit
    issue(23'h000001, 24'h000002, 5'd4);
    backToBack(23'h001234, 23'h004321);
    repeat (10) @(posedge clk);
    @(negedge clk);
    checks++;
    if (expQ.size() != 0 || dataQ.size() != 0) begin
      failures++;
      $display("FAIL R9 pending model entries actual=%0d expected=0", expQ.size() + dataQ.size());
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule